// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block turns a set of free-running prescaler tap signals from a real-time clock into a periodic interrupt. A three-bit rate code in a byte-wide control register picks one of six taps, spaced at 256, 64, 16, 4, 2 and 1 Hz, or turns the generator off. Each rising edge of the chosen tap marks one elapsed period and sets a sticky period flag. The interrupt line follows that flag while a valid rate is selected.

Software writes the control byte through a simple write strobe. Writing 0 to the flag position clears the flag. Writing 1 there leaves it as it is. Clearing the rate code and the flag in one write shuts the generator down. The low nibble of the byte belongs to neighbouring clock-enable logic, and this block ignores it.

Top module: `pirq_periodic_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, the flag is 0, the interrupt is 0 and the rate code reads 0. A tap that is already high when reset is released produces no event until it falls and rises again.
- R2: A write loads wr_data_i bits 6:4 into the rate code, which is visible on rate_sel_o in the cycle after the write. Bits 3:0 have no effect on any output.
- R3: Rate code c (1 to 6) selects tap_i bit c-1, where bit 0 is the 256 Hz tap and bit 5 is the 1 Hz tap. A rising edge of the selected tap that is sampled at a clock edge sets the flag at that same edge.
- R4: Only rising edges set the flag. A tap held high gives one event. Edges on taps that are not selected have no effect.
- R5: Rate codes 0 and 7 never set the flag and hold the interrupt low.
- R6: A write with bit 7 equal to 0 clears the flag. A write with bit 7 equal to 1 leaves the flag unchanged.
- R7: A period event in the same cycle as a clearing write leaves the flag set.
- R8: irq_o is 1 exactly when the flag is set and the rate code is in the range 1 to 6. A flag that survives a change to code 0 or 7 therefore stays visible but does not interrupt.
- R9: After a change of rate code, a newly selected tap that is already high gives no event. The first event comes at that tap's next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_i | input | 6 | Prescaler tap levels, bit 0 fastest (256 Hz) to bit 5 slowest (1 Hz) |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte: bit 7 flag, bits 6:4 rate code, bits 3:0 ignored |
| rate_sel_o | output | 3 | Current rate code |
| flag_o | output | 1 | Sticky period flag |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The hardest case to reach is a period event landing in the exact cycle that software clears the flag. The stimulus table drives a rising edge of the selected tap together with a clearing write in one vector, and the flag must stay set. A second hard case is a rate change while the newly selected tap is already high. This is reached by raising every tap before writing the new code, and then checking that the first event waits for a fresh rising edge. The directed part also drives a 4 Hz pulse train with a clear after each event, and counts exactly one flag per period.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int TAP_CNT  = 6;
    localparam int CODE_W   = 3;
    localparam int REG_W    = 8;
    localparam int FLAG_POS = 7;
    localparam int CODE_LSB = 4;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        RATE_OFF  = 3'd0,
        RATE_256  = 3'd1,
        RATE_64   = 3'd2,
        RATE_16   = 3'd3,
        RATE_4    = 3'd4,
        RATE_2    = 3'd5,
        RATE_1    = 3'd6,
        RATE_RSVD = 3'd7
    } rate_code_e;

    typedef struct packed {
        logic       strobe;
        logic       keep_flag;
        rate_code_e code;
    } ctrl_wr_t;

    // A code is live when it names an existing tap.
    function automatic logic code_live(input logic [CODE_W-1:0] c);
        return (c != '0) && (int'(c) <= TAP_CNT);
    endfunction

    // Tap index served by a live code.
    function automatic logic [CODE_W-1:0] code_tap(input logic [CODE_W-1:0] c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

    function automatic ctrl_wr_t decode_wr(input logic en, input logic [REG_W-1:0] d);
        ctrl_wr_t w;
        w.strobe    = en;
        w.keep_flag = d[FLAG_POS];
        w.code      = rate_code_e'(d[CODE_MSB:CODE_LSB]);
        return w;
    endfunction

endpackage

// File: rtl/pirq_edge_detect.sv
module pirq_edge_detect #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] lvl_q;

    // Sampled also during reset so that a tap high at release is not an edge.
    always_ff @(posedge clk) begin
        lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pirq_rate_mux.sv
module pirq_rate_mux
    import pirq_pkg::*;
#(
    parameter int W = TAP_CNT
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [W-1:0]      rise_i,
    output logic              event_o
);
    logic [W-1:0] hit;

    for (genvar g = 0; g < W; g++) begin : g_tap
        assign hit[g] = (code_i == CODE_W'(g + 1)) && rise_i[g];
    end

    assign event_o = |hit;
endmodule

// File: rtl/pirq_ctrl_reg.sv
module pirq_ctrl_reg
    import pirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_wr_t   wr_i,
    output rate_code_e code_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= RATE_OFF;
        end else if (wr_i.strobe) begin
            code_o <= wr_i.code;
        end
    end
endmodule

// File: rtl/pirq_flag.sv
module pirq_flag
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              event_i,
    input  ctrl_wr_t          wr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              flag_o,
    output logic              irq_o
);
    logic clr;

    assign clr = wr_i.strobe && !wr_i.keep_flag;

    // A period event wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (event_i) begin
            flag_o <= 1'b1;
        end else if (clr) begin
            flag_o <= 1'b0;
        end
    end

    assign irq_o = flag_o && code_live(code_i);
endmodule

// File: rtl/pirq_periodic_gen.sv
module pirq_periodic_gen
    import pirq_pkg::*;
#(
    parameter int NTAP = TAP_CNT,
    parameter int DW   = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTAP-1:0]   tap_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [CODE_W-1:0] rate_sel_o,
    output logic              flag_o,
    output logic              irq_o
);
    ctrl_wr_t   wr;
    rate_code_e code;
    logic [NTAP-1:0] rise;
    logic       period_evt;

    assign wr = decode_wr(wr_en_i, REG_W'(wr_data_i));

    pirq_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .code_o (code)
    );

    pirq_edge_detect #(.W(NTAP)) u_edge (
        .clk    (clk),
        .lvl_i  (tap_i),
        .rise_o (rise)
    );

    pirq_rate_mux #(.W(NTAP)) u_mux (
        .code_i  (code),
        .rise_i  (rise),
        .event_o (period_evt)
    );

    pirq_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .event_i (period_evt),
        .wr_i    (wr),
        .code_i  (code),
        .flag_o  (flag_o),
        .irq_o   (irq_o)
    );

    assign rate_sel_o = code;
endmodule

// File: rtl/pirq_periodic_gen_chk.sv
module pirq_periodic_gen_chk
    import pirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [TAP_CNT-1:0] tap_i,
    input logic              wr_en_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [CODE_W-1:0] rate_sel_o,
    input logic              flag_o,
    input logic              irq_o
);
    logic [TAP_CNT-1:0] tap_prev;
    logic               sel_rise;
    logic               clr_wr;

    always_ff @(posedge clk) tap_prev <= tap_i;

    assign sel_rise = code_live(rate_sel_o)
                   && tap_i[code_tap(rate_sel_o)] && !tap_prev[code_tap(rate_sel_o)];
    assign clr_wr   = wr_en_i && !wr_data_i[FLAG_POS];

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!flag_o && rate_sel_o == '0));

    assert_code_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> rate_sel_o == $past(wr_data_i[CODE_MSB:CODE_LSB]));

    assert_set_only_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(sel_rise));

    assert_dead_codes_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rate_sel_o == '0 || rate_sel_o == '1) |-> !irq_o);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !sel_rise) |=> !flag_o);

    assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && sel_rise) |=> flag_o);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        !flag_o |-> !irq_o);
endmodule

bind pirq_periodic_gen pirq_periodic_gen_chk u_chk (.*);

// File: tb/pirq_periodic_gen_test.sv
`timescale 1ns/1ps
module pirq_periodic_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] tap = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] rate_sel;
    logic       flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pirq_periodic_gen uut (
        .clk        (clk),
        .rst        (rst),
        .tap_i      (tap),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rate_sel_o (rate_sel),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic [5:0] taps;
        logic       ef;
        logic       ei;
        logic [2:0] es;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h1F, 6'b000000, 1'b0, 1'b0, 3'd1}, // R2 code 1, low nibble ignored
        '{1'b0, 8'h00, 6'b000001, 1'b1, 1'b1, 3'd1}, // R3 tap0 rise
        '{1'b0, 8'h00, 6'b000001, 1'b1, 1'b1, 3'd1}, // R4 held high, flag sticky
        '{1'b1, 8'h10, 6'b000001, 1'b0, 1'b0, 3'd1}, // R6 clear, no new edge
        '{1'b0, 8'h00, 6'b000000, 1'b0, 1'b0, 3'd1},
        '{1'b0, 8'h00, 6'b000010, 1'b0, 1'b0, 3'd1}, // R4 unselected tap
        '{1'b0, 8'h00, 6'b000011, 1'b1, 1'b1, 3'd1}, // R3 second period
        '{1'b1, 8'h9A, 6'b000011, 1'b1, 1'b1, 3'd1}, // R6 writing 1 keeps flag
        '{1'b1, 8'h00, 6'b000000, 1'b0, 1'b0, 3'd0}, // R6 full shutdown
        '{1'b0, 8'h00, 6'b111111, 1'b0, 1'b0, 3'd0}, // R5 code 0 ignores edges
        '{1'b1, 8'h70, 6'b000000, 1'b0, 1'b0, 3'd7},
        '{1'b0, 8'h00, 6'b111111, 1'b0, 1'b0, 3'd7}, // R5 code 7 ignores edges
        '{1'b1, 8'h60, 6'b111111, 1'b0, 1'b0, 3'd6}, // R9 new tap already high
        '{1'b0, 8'h00, 6'b011111, 1'b0, 1'b0, 3'd6},
        '{1'b0, 8'h00, 6'b111111, 1'b1, 1'b1, 3'd6}, // R9 next rise of new tap
        '{1'b1, 8'h60, 6'b011111, 1'b0, 1'b0, 3'd6}, // R6 clear
        '{1'b1, 8'h65, 6'b111111, 1'b1, 1'b1, 3'd6}, // R7 event beats clear
        '{1'b1, 8'h80, 6'b111111, 1'b1, 1'b0, 3'd0}, // R8 flag kept, code 0 masks irq
        '{1'b1, 8'hD3, 6'b111111, 1'b1, 1'b1, 3'd5}, // R8 irq returns with code 5
        '{1'b1, 8'hF0, 6'b111111, 1'b1, 1'b0, 3'd7}  // R8 code 7 masks irq
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic [5:0] t);
        @(negedge clk);
        wr_en   = w;
        wr_data = d;
        tap     = t;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nflag;
        repeat (4) @(posedge clk);
        #1;
        check("R1", "flag in reset", int'(flag), 0);
        check("R1", "irq in reset", int'(irq), 0);
        check("R1", "code in reset", int'(rate_sel), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].data, VEC[i].taps);
            check($sformatf("vec%0d", i), "flag", int'(flag), int'(VEC[i].ef));
            check($sformatf("vec%0d", i), "irq", int'(irq), int'(VEC[i].ei));
            check($sformatf("vec%0d", i), "code", int'(rate_sel), int'(VEC[i].es));
        end

        // R1: reset in the middle of a run, with taps held high
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "flag after mid reset", int'(flag), 0);
        check("R1", "code after mid reset", int'(rate_sel), 0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 8'h10, 6'b111111);
        step(1'b0, 8'h00, 6'b111111);
        check("R1", "no event from tap high at release", int'(flag), 0);

        // R3: 4 Hz code counts one flag per tap3 period
        step(1'b1, 8'h40, 6'b000000);
        nflag = 0;
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 3; k++) begin
                step(1'b0, 8'h00, 6'b001000);
                if (k == 0 && flag) nflag++;
            end
            step(1'b1, 8'h40, 6'b000000);
            step(1'b0, 8'h00, 6'b000111);
            step(1'b0, 8'h00, 6'b000000);
        end
        check("R3", "4 Hz event count", nflag, 5);
        check("R4", "flag clear after train", int'(flag), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule